// File: doc/BRIEF.md
# Hashed Page Table Lookup Engine

This block resolves a virtual address into a physical address by searching an inverted page table kept in ordinary memory. The table has a power-of-two number of slots and is usually provisioned at about four times the number of physical page frames, so that chains of colliding entries stay short. A lookup hashes the virtual page number together with the process identifier to choose a home slot. It then reads slots one after another until it finds the owning entry, an empty slot or a configured probe limit.

Every slot takes eight bytes in two 32-bit words. The first word carries a valid flag, the owning process and the page tag. The second word carries the physical frame and an attribute field, which holds the dirty flag and the read, write and execute permissions. The engine reads the second word only after the first word matches. This means a collision costs one memory read per examined slot. The engine keeps at most one memory read outstanding and serves one translation at a time. Filling the table, evicting entries and handling the resulting fault are the job of other agents.

Top module: `hpt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_rd_req` are 0.
- R2: The virtual page number is `req_vaddr[31:12]`. The home slot is `(vpn XOR zero-extended pid)` reduced modulo `2**cfg_slot_log2`, with `cfg_slot_log2` in 1..20. The first read of a lookup goes to `cfg_table_base + 8*home`.
- R3: Slot word 0 uses bit 31 as valid, bits 30:28 as reserved, bits 27:20 as the process ID and bits 19:0 as the page tag. A slot matches only when it is valid, its reserved bits are zero, its process ID equals the request's process ID and its tag equals the request's page number. The same page under another process ID therefore does not match.
- R4: Word 1 of a slot is read at slot address + 4, and only right after that slot's word 0 has matched. A lookup therefore issues exactly (probes + 1) reads on a hit and (probes) reads on a fault.
- R5: On a hit, `rsp_fault` is 0 and `rsp_paddr` is `{word1[31:12], req_vaddr[11:0]}`. `rsp_attr` is `word1[11:0]`, where bit 3 is dirty, bit 2 is read, bit 1 is write and bit 0 is execute.
- R6: After a valid slot that does not match, the next probe goes to slot `(s+1) mod 2**cfg_slot_log2`, wrapping from the last slot to slot 0. Every read address lies inside the table.
- R7: A slot whose valid bit is 0 ends the lookup with `rsp_fault`=1, with that slot included in `rsp_probes`. On a fault, `rsp_paddr` and `rsp_attr` are 0.
- R8: When a valid, non-matching slot is the `cfg_probe_limit`-th probe (limit of at least 1), the lookup ends with `rsp_fault`=1 and `rsp_probes` equal to the limit.
- R9: On a hit, `rsp_probes` is the 1-based position of the matching slot in the probe sequence.
- R10: `mem_rd_req` stays high with a stable `mem_rd_addr` until `mem_rd_ack`, and no further read starts within that cycle.
- R11: `req_ready` is high only while no lookup is in progress. Each accepted request produces exactly one single-cycle `rsp_valid` pulse. The base, slot count and probe limit are captured when the request is accepted, and later changes to them do not affect that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Engine idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_pid | input | 8 | Requesting process identifier |
| cfg_table_base | input | 32 | Byte address of slot 0 |
| cfg_slot_log2 | input | 5 | log2 of the slot count (1..20) |
| cfg_probe_limit | input | 8 | Maximum slots examined per lookup |
| mem_rd_req | output | 1 | Memory read request, held until acknowledged |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_ack | input | 1 | Read data valid, completes the request |
| mem_rd_data | input | 32 | Read data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation not found |
| rsp_paddr | output | 32 | Physical address on a hit |
| rsp_attr | output | 12 | Attribute field of the entry on a hit |
| rsp_probes | output | 8 | Number of slots examined |

## Verification
The assertions assume that `mem_rd_ack` is raised only while `mem_rd_req` is high. They also assume that `cfg_probe_limit` is at least 1 and that `cfg_slot_log2` stays in 1..20. The bench's memory responder acknowledges only a pending read, after 0 to 2 idle cycles, and always pulls the acknowledge low again in the following cycle. Every random and directed lookup uses a slot count of 8 or 64 and a probe limit from 1 to 10.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  parameter int VA_W    = 32;
  parameter int PAGE_W  = 12;
  parameter int VPN_W   = VA_W - PAGE_W;
  parameter int PID_W   = 8;
  parameter int LOG2_W  = 5;
  parameter int PROBE_W = 8;
  parameter int RSV_W   = VA_W - 1 - PID_W - VPN_W;
  parameter int SLOT_SH = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_TAG, ST_MAP} walk_state_t;

  // all-ones in the low lg bits of a slot index
  function automatic logic [VPN_W-1:0] slot_mask(input logic [LOG2_W-1:0] lg);
    return ~({VPN_W{1'b1}} << lg);
  endfunction

  function automatic logic [VPN_W-1:0] hash_slot(input logic [VPN_W-1:0] vpn,
                                                 input logic [PID_W-1:0] pid,
                                                 input logic [VPN_W-1:0] mask);
    return (vpn ^ VPN_W'(pid)) & mask;
  endfunction

  function automatic logic [VA_W-1:0] slot_addr(input logic [VA_W-1:0] base,
                                                input logic [VPN_W-1:0] slot,
                                                input logic map_word);
    return base + (VA_W'(slot) << SLOT_SH) + (map_word ? VA_W'(4) : VA_W'(0));
  endfunction
endpackage

// File: rtl/hpt_slot_gen.sv
module hpt_slot_gen
  import hpt_pkg::*;
(
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [PID_W-1:0] req_pid,
  input  logic [VPN_W-1:0] home_mask,
  input  logic [VPN_W-1:0] cur_slot,
  input  logic [VPN_W-1:0] wrap_mask,
  output logic [VPN_W-1:0] home_slot,
  output logic [VPN_W-1:0] next_slot
);
  assign home_slot = hash_slot(req_vpn, req_pid, home_mask);
  assign next_slot = (cur_slot + VPN_W'(1)) & wrap_mask;
endmodule

// File: rtl/hpt_tag_match.sv
module hpt_tag_match
  import hpt_pkg::*;
(
  input  logic [VA_W-1:0]  word0,
  input  logic [VPN_W-1:0] vpn,
  input  logic [PID_W-1:0] pid,
  output logic             slot_live,
  output logic             tag_hit
);
  assign slot_live = word0[VA_W-1];
  assign tag_hit   = slot_live && (word0[VA_W-2:0] == {{RSV_W{1'b0}}, pid, vpn});
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [PID_W-1:0]   req_pid,
  input  logic [VA_W-1:0]    cfg_table_base,
  input  logic [LOG2_W-1:0]  cfg_slot_log2,
  input  logic [PROBE_W-1:0] cfg_probe_limit,
  output logic               mem_rd_req,
  output logic [VA_W-1:0]    mem_rd_addr,
  input  logic               mem_rd_ack,
  input  logic [VA_W-1:0]    mem_rd_data,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [VA_W-1:0]    rsp_paddr,
  output logic [PAGE_W-1:0]  rsp_attr,
  output logic [PROBE_W-1:0] rsp_probes
);
  walk_state_t        state_q;
  logic [VA_W-1:0]    vaddr_q, base_q;
  logic [PID_W-1:0]   pid_q;
  logic [VPN_W-1:0]   mask_q, slot_q;
  logic [PROBE_W-1:0] lim_q, probes_q;

  logic               rsp_valid_q, rsp_fault_q;
  logic [VA_W-1:0]    rsp_paddr_q;
  logic [PAGE_W-1:0]  rsp_attr_q;
  logic [PROBE_W-1:0] rsp_probes_q;

  logic [VPN_W-1:0]   home_slot, next_slot;
  logic               slot_live, tag_hit;

  hpt_slot_gen u_slot_gen (
    .req_vpn   (req_vaddr[VA_W-1:PAGE_W]),
    .req_pid   (req_pid),
    .home_mask (slot_mask(cfg_slot_log2)),
    .cur_slot  (slot_q),
    .wrap_mask (mask_q),
    .home_slot (home_slot),
    .next_slot (next_slot)
  );

  hpt_tag_match u_tag_match (
    .word0     (mem_rd_data),
    .vpn       (vaddr_q[VA_W-1:PAGE_W]),
    .pid       (pid_q),
    .slot_live (slot_live),
    .tag_hit   (tag_hit)
  );

  // named events for the FSM and the assertions
  logic accept, in_map, tag_ack, lim_reached, end_fault, advance, map_done;
  assign req_ready   = (state_q == ST_IDLE);
  assign accept      = req_ready && req_valid;
  assign in_map      = (state_q == ST_MAP);
  assign tag_ack     = (state_q == ST_TAG) && mem_rd_ack;
  assign lim_reached = (probes_q >= lim_q);
  assign end_fault   = tag_ack && (!slot_live || (!tag_hit && lim_reached));
  assign advance     = tag_ack && slot_live && !tag_hit && !lim_reached;
  assign map_done    = in_map && mem_rd_ack;

  assign mem_rd_req  = (state_q != ST_IDLE);
  assign mem_rd_addr = slot_addr(base_q, slot_q, in_map);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      vaddr_q      <= '0;
      base_q       <= '0;
      pid_q        <= '0;
      mask_q       <= '0;
      slot_q       <= '0;
      lim_q        <= '0;
      probes_q     <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_fault_q  <= 1'b0;
      rsp_paddr_q  <= '0;
      rsp_attr_q   <= '0;
      rsp_probes_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          vaddr_q  <= req_vaddr;
          pid_q    <= req_pid;
          base_q   <= cfg_table_base;
          mask_q   <= slot_mask(cfg_slot_log2);
          lim_q    <= cfg_probe_limit;
          slot_q   <= home_slot;
          probes_q <= PROBE_W'(1);
          state_q  <= ST_TAG;
        end
        ST_TAG: begin
          if (tag_ack && tag_hit) state_q <= ST_MAP;
          if (advance) begin
            slot_q   <= next_slot;
            probes_q <= probes_q + PROBE_W'(1);
          end
          if (end_fault) begin
            state_q      <= ST_IDLE;
            rsp_valid_q  <= 1'b1;
            rsp_fault_q  <= 1'b1;
            rsp_paddr_q  <= '0;
            rsp_attr_q   <= '0;
            rsp_probes_q <= probes_q;
          end
        end
        ST_MAP: if (map_done) begin
          state_q      <= ST_IDLE;
          rsp_valid_q  <= 1'b1;
          rsp_fault_q  <= 1'b0;
          rsp_paddr_q  <= {mem_rd_data[VA_W-1:PAGE_W], vaddr_q[PAGE_W-1:0]};
          rsp_attr_q   <= mem_rd_data[PAGE_W-1:0];
          rsp_probes_q <= probes_q;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_fault  = rsp_fault_q;
  assign rsp_paddr  = rsp_paddr_q;
  assign rsp_attr   = rsp_attr_q;
  assign rsp_probes = rsp_probes_q;

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr))); // R10
  AST_MAP_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_map) |-> $past(tag_hit && mem_rd_ack)); // R4
  AST_READ_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (((mem_rd_addr - base_q) >> SLOT_SH) <= VA_W'(mask_q))); // R6
  AST_PROBE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_probes != '0 && (rsp_probes <= lim_q || lim_q == '0))); // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11
  AST_FAULT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_attr == '0)); // R7
endmodule

// File: tb/test_hpt_walker.sv
module test_hpt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_pid = '0;
  logic [31:0] cfg_table_base = 32'h0004_0000;
  logic [4:0]  cfg_slot_log2 = 5'd3;
  logic [7:0]  cfg_probe_limit = 8'd8;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ack = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [11:0] rsp_attr;
  logic [7:0]  rsp_probes;

  hpt_walker i_hpt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_pid(req_pid), .cfg_table_base(cfg_table_base),
    .cfg_slot_log2(cfg_slot_log2), .cfg_probe_limit(cfg_probe_limit),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr), .rsp_probes(rsp_probes)
  );

  always #10 clk = ~clk;

  logic [31:0] mem [0:127];
  logic [31:0] rec_addr [0:63];
  int          rec_n;
  logic [31:0] exp_addr [0:63];
  int          exp_n;
  logic        exp_fault;
  logic [31:0] exp_paddr;
  logic [11:0] exp_attr;
  int          exp_probes;
  int          n_checks = 0, n_fail = 0;
  bit          hung = 0;
  logic [19:0] ins_vpn [0:39];
  logic [7:0]  ins_pid [0:39];

  // memory responder: acks a pending read after 0..2 idle cycles
  initial begin
    int wait_cnt;
    wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_rd_ack) mem_rd_ack = 1'b0;
      else if (mem_rd_req) begin
        if (wait_cnt == 0) begin
          mem_rd_ack  = 1'b1;
          mem_rd_data = mem[((mem_rd_addr - cfg_table_base) >> 2) & 32'd127];
          if (rec_n < 64) rec_addr[rec_n] = mem_rd_addr;
          rec_n++;
          wait_cnt = $urandom % 3;
        end else wait_cnt--;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int b_home(input logic [19:0] vpn, input logic [7:0] pid, input int lg);
    return int'({12'd0, vpn ^ {12'd0, pid}} % (32'd1 << lg));
  endfunction

  // independent walk of the table as the requirements describe it
  task automatic model(input logic [31:0] va, input logic [7:0] pid, input int lim);
    int s, k, slots;
    logic [31:0] w0, w1;
    slots = 1 << cfg_slot_log2;
    s = b_home(va[31:12], pid, cfg_slot_log2);
    k = 1; exp_n = 0;
    exp_fault = 1'b1; exp_paddr = '0; exp_attr = '0;
    for (int it = 0; it < 300; it++) begin
      exp_addr[exp_n] = cfg_table_base + 32'(s * 8); exp_n++;
      w0 = mem[2*s];
      if (!w0[31]) break;
      if (w0[30:0] == {3'b000, pid, va[31:12]}) begin
        exp_addr[exp_n] = cfg_table_base + 32'(s * 8 + 4); exp_n++;
        w1 = mem[2*s+1];
        exp_fault = 1'b0;
        exp_paddr = {w1[31:12], va[11:0]};
        exp_attr  = w1[11:0];
        break;
      end
      if (k >= lim) break;
      s = (s + 1) % slots;
      k++;
    end
    exp_probes = k;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] pid,
                        input int lim, input int lim_after);
    int cyc;
    if (hung) return;
    model(va, pid, lim);
    rec_n = 0;
    @(negedge clk);
    req_vaddr = va; req_pid = pid; cfg_probe_limit = 8'(lim); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_probe_limit = 8'(lim_after);  // R11: must not affect this lookup
    cyc = 0;
    while (!rsp_valid && cyc < 2000) begin @(negedge clk); cyc++; end
    if (!rsp_valid) begin
      hung = 1;
      check(0, "watchdog", cyc, 0);
      return;
    end
    check(rec_n == exp_n, "R4 read count", rec_n, exp_n);
    check(rec_n > 0 && rec_addr[0] == exp_addr[0], "R2 home address", rec_addr[0], exp_addr[0]);
    for (int i = 1; i < exp_n && i < rec_n; i++)
      check(rec_addr[i] == exp_addr[i], "R6 probe address", rec_addr[i], exp_addr[i]);
    check(rsp_fault == exp_fault, exp_fault ? "R7 R8 fault" : "R3 hit", rsp_fault, exp_fault);
    check(rsp_probes == 8'(exp_probes), "R9 probes", rsp_probes, exp_probes);
    check(rsp_paddr == exp_paddr, "R5 paddr", rsp_paddr, exp_paddr);
    check(rsp_attr == exp_attr, "R5 attr", rsp_attr, exp_attr);
    @(negedge clk);
    check(!rsp_valid, "R11 single pulse", rsp_valid, 0);
  endtask

  task automatic put(input int s, input logic [19:0] vpn, input logic [7:0] pid,
                     input logic [19:0] ppn, input logic [11:0] attr);
    mem[2*s]   = {1'b1, 3'b000, pid, vpn};
    mem[2*s+1] = {ppn, attr};
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) mem[i] = '0;
    rec_n = 0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_req == 1'b0, "R1 reset",
          {req_ready, rsp_valid, mem_rd_req}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);

    // directed table, 8 slots
    cfg_slot_log2 = 5'd3;
    put(1, 20'h12340, 8'h01, 20'hAAAAA, 12'h00D);  // home 1
    put(2, 20'h55551, 8'h00, 20'hBBBBB, 12'h006);  // home 1, collided
    put(7, 20'h00007, 8'h00, 20'hCCCCC, 12'h004);  // home 7
    put(0, 20'h0000F, 8'h00, 20'hDDDDD, 12'h00B);  // home 7, wrapped
    put(4, 20'h00004, 8'h00, 20'hEEEEE, 12'h001);
    mem[8] = mem[8] | 32'h1000_0000;               // R3: reserved bit set, never matches
    lookup({20'h12340, 12'h5A5}, 8'h01, 8, 8);     // R9 home hit, 1 probe
    lookup({20'h55551, 12'h001}, 8'h00, 8, 8);     // R6 collision, 2 probes
    lookup({20'h0000F, 12'hFFF}, 8'h00, 8, 8);     // R6 wraparound 7 -> 0
    lookup({20'h12340, 12'h000}, 8'h09, 8, 8);     // R3 other pid, fault at empty slot 3
    lookup({20'h00006, 12'h000}, 8'h00, 8, 8);     // R7 empty home slot
    lookup({20'h00004, 12'h123}, 8'h00, 8, 8);     // R3 reserved bits -> fault after 2
    lookup({20'h00017, 12'h000}, 8'h00, 3, 8);     // R8 limit 3, R11 later raise ignored
    lookup({20'h0000F, 12'h000}, 8'h00, 1, 8);     // R8 limit 1
    lookup({20'h00017, 12'h000}, 8'h00, 8, 1);     // R7 chain to empty slot 3

    // random table, 64 slots
    cfg_slot_log2 = 5'd6;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    for (int e = 0; e < 40; e++) begin
      int s;
      ins_vpn[e] = 20'($urandom);
      ins_pid[e] = 8'(1 + $urandom % 3);
      s = b_home(ins_vpn[e], ins_pid[e], 6);
      for (int t = 0; t < 64 && mem[2*s][31]; t++) s = (s + 1) % 64;
      put(s, ins_vpn[e], ins_pid[e], 20'($urandom), 12'($urandom));
    end
    for (int n = 0; n < 150; n++) begin
      int e, lim;
      logic [19:0] v;
      logic [7:0] p;
      e = $urandom % 40;
      lim = 1 + $urandom % 10;
      if ($urandom % 2 == 0) begin v = ins_vpn[e]; p = ins_pid[e]; end
      else begin v = 20'($urandom); p = 8'($urandom % 4); end
      lookup({v, 12'($urandom)}, p, lim, 1 + $urandom % 10);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule